// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block moves a group of general registers to or from memory in a single operation. The block receives one start pulse together with a base address, a 5-bit list field, a direction bit and a size bit. From these it produces a series of single memory transfers, one for each selected register. Stores read each register through a read port of the register file and send the value as a memory write. Loads wait for each memory response and write the returned value into the register file.

The list field does not hold a bitmap. Its low four bits give how many entries to take, in order, from a fixed table of callee-saved registers. Bit 4 adds one transfer of the link register (register 31), and that transfer always comes last. Addresses start at the base and rise by the transfer size. Each memory request waits on a request/acknowledge handshake. The block shows `busy` while it runs and pulses `done` when it has finished.

Top module: `lsm_seq`

## Requirements
- R1: A start is accepted only while `busy` is low. `busy` rises in the cycle after an accepted start that selects at least one transfer. A start seen while `busy` is high changes nothing. No memory request is issued while `busy` is low.
- R2: Bits [3:0] of `list_field` form a count. A count from 1 to 9 selects that many table transfers. A count of 0, or from 10 to 15, selects no table transfers.
- R3: Table transfers use registers 16, 17, 18, 19, 20, 21, 22, 23, 30, in that order, starting from the first entry.
- R4: When bit 4 of `list_field` is 1, register 31 is transferred after all table transfers. Its address follows the last table address, or equals the base when no table transfers were selected.
- R5: The first transfer uses `base_addr`. Each later address is 4 higher for word size (`dword`=0) or 8 higher for doubleword size (`dword`=1), modulo 2^ADDR_W.
- R6: A load (`is_store`=0) writes the register once per transfer, one cycle after the handshake. Word data is bits [31:0] of `mem_rdata`, sign-extended to 64 bits. Doubleword data is all 64 bits.
- R7: A store (`is_store`=1) writes no register. `mem_wdata` holds the full register for doubleword size. For word size it holds the low 32 bits with the upper 32 bits at zero. `mem_we` and `mem_dword` follow the direction and size of the operation.
- R8: A request stays asserted, with a stable address, until `mem_ack` is seen. The next transfer begins only after that handshake. `mem_req` is low in the cycle after a handshake.
- R9: `done` is a one-cycle pulse in the cycle after the handshake of the last transfer, and `busy` falls in that same cycle.
- R10: A start that selects no transfers at all produces no memory request and does not raise `busy`. It pulses `done` in the cycle after the start.
- R11: After reset, `busy`, `done`, `mem_req` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken when idle) |
| list_field | input | LIST_W | [3:0] table count, [4] link-register flag |
| base_addr | input | ADDR_W | First transfer address |
| is_store | input | 1 | 1 = store registers, 0 = load registers |
| dword | input | 1 | 1 = 64-bit transfers, 0 = 32-bit transfers |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_idx | output | 5 | Register-file read index (stores) |
| rf_rd_data | input | DATA_W | Register-file read data for `rf_rd_idx` |
| rf_wr_en | output | 1 | Register-file write strobe (loads) |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| mem_req | output | 1 | Memory request valid |
| mem_ack | input | 1 | Memory handshake complete; load data valid |
| mem_we | output | 1 | Request is a write |
| mem_dword | output | 1 | Request is 64-bit |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bench targets three groups of cases: counts at the table limits (1, 9, 10, 15), the link-register flag alone, and the link-register flag combined with a full or out-of-range count. A decoder that treated counts 10 to 15 as valid would issue extra requests past the table. A design that placed register 31 at the wrong position would return a mismatched register value or address. Memory stalls are drawn from a pseudo-random pattern, so an engine that advanced without the handshake would skip addresses or drop load data. Word loads use data with bit 31 both set and clear, which catches a zero-extend where a sign-extend belongs. Starts pulsed while an operation is running, with different inputs, expose a block that re-latches its parameters.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int REG_W     = 5;
  localparam int TABLE_LEN = 9;
  localparam int COUNT_W   = 4;
  localparam int STEP_W    = $clog2(TABLE_LEN + 2);
  localparam logic [REG_W-1:0] LINK_REG = 5'd31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

  // Fixed transfer table: 16..23, then 30.
  function automatic logic [REG_W-1:0] table_reg(input int pos);
    if (pos < 8) return REG_W'(16 + pos);
    return REG_W'(30);
  endfunction
endpackage

// File: rtl/lsm_list_decode.sv
module lsm_list_decode
  import lsm_pkg::*;
#(
  parameter int LIST_W = 5
) (
  input  logic [LIST_W-1:0] list_field,
  output logic [STEP_W-1:0] tbl_cnt,
  output logic              link_flag,
  output logic [STEP_W-1:0] total
);
  logic [COUNT_W-1:0] raw_cnt;
  logic               cnt_ok;

  assign raw_cnt   = list_field[COUNT_W-1:0];
  assign link_flag = list_field[COUNT_W];
  assign cnt_ok    = (raw_cnt != '0) && (32'(raw_cnt) <= TABLE_LEN);

  always_comb begin
    tbl_cnt = cnt_ok ? STEP_W'(raw_cnt) : '0;
    total   = tbl_cnt + STEP_W'(link_flag);
  end
endmodule

// File: rtl/lsm_reg_select.sv
module lsm_reg_select
  import lsm_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] tbl_cnt,
  output logic [REG_W-1:0]  reg_idx
);
  localparam int LUT_N = 2 ** STEP_W;

  logic [REG_W-1:0] lut [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    if (g < TABLE_LEN) begin : g_tbl
      assign lut[g] = table_reg(g);
    end else begin : g_pad
      assign lut[g] = LINK_REG;
    end
  end

  assign reg_idx = (step < tbl_cnt) ? lut[step] : LINK_REG;
endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              dword,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] stride;

  assign stride = dword ? ADDR_W'(8) : ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (rst)          addr <= '0;
    else if (load)    addr <= base;
    else if (advance) addr <= addr + stride;
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int LIST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LIST_W-1:0] list_field,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              is_store,
  input  logic              dword,
  output logic              busy,
  output logic              done,
  output logic [REG_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [REG_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic              mem_we,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int EXT_W = DATA_W - WORD_W;

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] tbl_q;
  logic [STEP_W-1:0] total_q;

  logic [STEP_W-1:0] dec_tbl;
  logic [STEP_W-1:0] dec_total;
  logic              dec_link;
  logic [STEP_W-1:0] sel_step;
  logic [STEP_W-1:0] sel_cnt;
  logic [REG_W-1:0]  sel_reg;
  logic              accept;
  logic              handshake;
  logic              last_xfer;
  logic [DATA_W-1:0] store_val;
  logic [DATA_W-1:0] load_val;

  lsm_list_decode #(.LIST_W(LIST_W)) u_dec (
    .list_field (list_field),
    .tbl_cnt    (dec_tbl),
    .link_flag  (dec_link),
    .total      (dec_total)
  );

  assign sel_step = (state == ST_IDLE) ? '0 : step + 1'b1;
  assign sel_cnt  = (state == ST_IDLE) ? dec_tbl : tbl_q;

  lsm_reg_select u_sel (
    .step    (sel_step),
    .tbl_cnt (sel_cnt),
    .reg_idx (sel_reg)
  );

  assign accept    = (state == ST_IDLE) && start && (dec_total != '0);
  assign handshake = (state == ST_WAIT) && mem_ack;
  assign last_xfer = ((step + 1'b1) == total_q);

  lsm_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .base    (base_addr),
    .advance (handshake),
    .dword   (mem_dword),
    .addr    (mem_addr)
  );

  assign store_val = mem_dword ? rf_rd_data
                               : {{EXT_W{1'b0}}, rf_rd_data[WORD_W-1:0]};
  assign load_val  = mem_dword ? mem_rdata
                               : {{EXT_W{mem_rdata[WORD_W-1]}}, mem_rdata[WORD_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      step       <= '0;
      tbl_q      <= '0;
      total_q    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rf_rd_idx  <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_dword  <= 1'b0;
      mem_wdata  <= '0;
    end else begin
      done     <= 1'b0;
      rf_wr_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (dec_total == '0) begin
              done <= 1'b1;
            end else begin
              busy      <= 1'b1;
              state     <= ST_PREP;
              step      <= '0;
              tbl_q     <= dec_tbl;
              total_q   <= dec_total;
              mem_we    <= is_store;
              mem_dword <= dword;
              rf_rd_idx <= sel_reg;
            end
          end
        end
        ST_PREP: begin
          mem_req   <= 1'b1;
          mem_wdata <= store_val;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (!mem_we) begin
              rf_wr_en   <= 1'b1;
              rf_wr_idx  <= rf_rd_idx;
              rf_wr_data <= load_val;
            end
            if (last_xfer) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              step      <= step + 1'b1;
              rf_rd_idx <= sel_reg;
              state     <= ST_PREP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rf_wr_en
);
  // R8: request held steady until acknowledged
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  // R8: request drops after handshake
  p_req_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: busy only ends together with done
  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R6: register write only after a load handshake
  p_wr_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> $past(mem_req && mem_ack && !mem_we));

  // R7: stores never write the register file
  p_store_no_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> !rf_wr_en);
endmodule

bind lsm_seq lsm_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .rf_wr_en  (rf_wr_en)
);

// File: tb/lsm_seq_test.sv
`timescale 1ns/1ps
module lsm_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  list_field = '0;
  logic [31:0] base_addr = '0;
  logic        is_store = 1'b0;
  logic        dword = 1'b0;
  logic        busy, done;
  logic [4:0]  rf_rd_idx;
  logic [63:0] rf_rd_data;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_idx;
  logic [63:0] rf_wr_data;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic        mem_we, mem_dword;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;

  always #2 clk = ~clk;

  lsm_seq uut (
    .clk(clk), .rst(rst), .start(start), .list_field(list_field),
    .base_addr(base_addr), .is_store(is_store), .dword(dword),
    .busy(busy), .done(done), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_dword(mem_dword),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [63:0] reg_val(input int r);
    logic [31:0] lo;
    lo = (32'(r) * 32'h0001_0203) | ((r % 2 == 1) ? 32'h8000_0000 : 32'h0);
    return {~lo ^ 32'h5A5A_0000, lo};
  endfunction

  function automatic logic [63:0] mem_val(input logic [31:0] a);
    logic [31:0] lo;
    lo = (a[3] ^ a[2]) ? (a | 32'h8000_0000) : (a & 32'h7FFF_FFFF);
    return {a ^ 32'hC0DE_0000, lo};
  endfunction

  assign rf_rd_data = reg_val(int'(rf_rd_idx));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int          q_reg[$];
  logic [31:0] q_addr[$];
  bit          m_busy = 0, m_store = 0, m_dw = 0;
  bit          exp_wr = 0, exp_done = 0;
  int          exp_idx = 0;
  logic [63:0] exp_data = '0;

  always @(posedge clk) begin
    exp_wr = 0;
    exp_done = 0;
    if (rst) begin
      m_busy = 0;
      q_reg.delete();
      q_addr.delete();
    end else if (mem_ack && q_reg.size() > 0) begin
      int r;
      logic [31:0] a;
      logic [63:0] d;
      r = q_reg.pop_front();
      a = q_addr.pop_front();
      if (!m_store) begin
        d = mem_val(a);
        exp_wr = 1;
        exp_idx = r;
        exp_data = m_dw ? d : {{32{d[31]}}, d[31:0]};
      end
      if (q_reg.size() == 0) begin
        exp_done = 1;
        m_busy = 0;
      end
    end else if (start && !m_busy) begin
      int n;
      logic [31:0] a;
      n = int'(list_field[3:0]);
      a = base_addr;
      m_store = is_store;
      m_dw = dword;
      if (n >= 1 && n <= 9) begin
        for (int i = 0; i < n; i++) begin
          q_reg.push_back(i < 8 ? 16 + i : 30);
          q_addr.push_back(a);
          a = a + (dword ? 32'd8 : 32'd4);
        end
      end
      if (list_field[4]) begin
        q_reg.push_back(31);
        q_addr.push_back(a);
      end
      if (q_reg.size() == 0) exp_done = 1;
      else m_busy = 1;
    end
  end

  bit          running = 0;
  bit          hold_pend = 0;
  logic [31:0] hold_addr = '0;
  logic [7:0]  lfsr = 8'hA5;
  int          cycles = 0;

  always @(negedge clk) begin
    if (running && !rst) begin
      cycles++;
      chk(busy === m_busy, "R1 busy", 64'(busy), 64'(m_busy));
      chk(done === exp_done, "R9 R10 done", 64'(done), 64'(exp_done));
      chk(rf_wr_en === exp_wr, "R6 R7 write strobe", 64'(rf_wr_en), 64'(exp_wr));
      if (exp_wr && rf_wr_en) begin
        chk(int'(rf_wr_idx) == exp_idx, "R3 R4 load register", 64'(rf_wr_idx), 64'(exp_idx));
        chk(rf_wr_data === exp_data, "R6 load data", rf_wr_data, exp_data);
      end
      if (hold_pend)
        chk(mem_req === 1'b1 && mem_addr === hold_addr, "R8 request held",
            {mem_req, mem_addr}, {1'b1, hold_addr});
      if (mem_req) begin
        chk(q_reg.size() > 0, "R2 R10 unexpected request", 64'(mem_addr), 64'(0));
        if (q_reg.size() > 0) begin
          logic [63:0] rv;
          rv = reg_val(q_reg[0]);
          chk(mem_addr === q_addr[0], "R5 address", 64'(mem_addr), 64'(q_addr[0]));
          chk(mem_we === m_store && mem_dword === m_dw, "R7 kind",
              {mem_we, mem_dword}, {m_store, m_dw});
          if (m_store)
            chk(mem_wdata === (m_dw ? rv : {32'h0, rv[31:0]}), "R3 R4 R7 store data",
                mem_wdata, m_dw ? rv : {32'h0, rv[31:0]});
        end
      end
      mem_ack   <= mem_req && (q_reg.size() > 0) && (lfsr[1:0] != 2'b00);
      mem_rdata <= mem_val(mem_addr);
      hold_pend = mem_req && !((q_reg.size() > 0) && (lfsr[1:0] != 2'b00));
      hold_addr = mem_addr;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic run_op(input logic [4:0] lst, input logic [31:0] base,
                        input bit st, input bit dw, input bit poke);
    @(negedge clk);
    list_field = lst; base_addr = base; is_store = st; dword = dw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke && m_busy) begin
      // R1: start with different parameters while busy must be ignored
      list_field = 5'd3; base_addr = 32'h0000_7700; is_store = ~st; dword = ~dw;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [4:0] lists [11];
    lists = '{5'd0, 5'd1, 5'd5, 5'd9, 5'd10, 5'd15, 5'd16, 5'd17, 5'd24, 5'd25, 5'd31};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && rf_wr_en === 1'b0,
        "R11 reset state", {busy, done, mem_req, rf_wr_en}, 64'(0));
    rst = 1'b0;
    running = 1;
    for (int dw = 0; dw < 2; dw++)
      for (int st = 0; st < 2; st++)
        for (int k = 0; k < 11; k++)
          run_op(lists[k], 32'h0000_1000 + 32'(k * 64 + dw * 8 + st * 4), bit'(st), bit'(dw), 1'b0);
    // address wrap, poke while busy
    run_op(5'd25, 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b1);
    run_op(5'd9, 32'h0000_2000, 1'b1, 1'b0, 1'b1);
    run_op(5'd17, 32'h0000_3004, 1'b0, 1'b0, 1'b1);
    run_op(5'd0, 32'h0000_4000, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule